// File: doc/BRIEF.md
# Indexed postbyte address generator

This block turns one indexed-addressing postbyte into a 16-bit effective address. It sits beside an instruction sequencer. The sequencer pulses `start` with the postbyte, and the block answers with a one-cycle `done` strobe. The strobe carries the address, an optional index-register writeback, the count of extra cycles the form costs, and a reject flag.

Forms that carry an offset in the instruction stream pull their extension bytes through a request/acknowledge fetch port. Forms that point through memory read one 16-bit word through a second request/acknowledge port.

The controller is a five-state machine:
- `ST_IDLE` waits for `start` and decodes the postbyte.
- `ST_FETCH_HI` takes the high offset byte.
- `ST_FETCH_LO` takes the low or only offset byte.
- `ST_PTR_RD` waits for the pointer word.
- `ST_DONE` presents the result for one cycle.

The transitions are as follows:
- From `ST_IDLE`, `start` leads to `ST_FETCH_LO` for the 9-bit form, `ST_FETCH_HI` for both 16-bit-offset forms, `ST_PTR_RD` for accumulator-D indirect, and `ST_DONE` for everything else or a rejected form.
- `ST_FETCH_HI` goes to `ST_FETCH_LO` on a fetch acknowledge.
- `ST_FETCH_LO` goes to `ST_PTR_RD` for the indirect form, and to `ST_DONE` otherwise, on a fetch acknowledge.
- `ST_PTR_RD` goes to `ST_DONE` on a read acknowledge.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `idx_agen`

## Requirements
- R1: With postbyte bit 5 = 0, the address is base + sign-extended bits 4:0 (bit 4 is the sign). The base is selected by bits 7:6: 0 = X, 1 = Y, 2 = SP, 3 = PC. `done` is high in the cycle after `start`, and no fetch or read is made.
- R2: With bit 5 = 1 and bits 7:6 not 11, the form is auto-modify. If bit 3 = 1, the amount is the low nibble minus 16 (−8..−1). If bit 3 = 0, the amount is the nibble plus 1 (1..8).
- R3: In auto-modify form, `wb_en` is high with `done`, `wb_sel` equals bits 7:6, and `wb_val` is base + amount. In every other form, `wb_en` stays low.
- R4: In auto-modify form, bit 4 = 0 gives the address base + amount (pre-modify). Bit 4 = 1 gives the unmodified base (post-modify).
- R5: With bits 7:5 = 111 and bit 2 = 0 (and bits 2:0 not 011), the base is selected by bits 4:3.
  - If bit 1 = 1, two bytes are fetched, high byte first, and their 16-bit value is added.
  - If bit 1 = 0, one byte is fetched and extended with bit 0 as its sign.
  - `extra_cycles` is 1 in both cases.
- R6: With bits 7:5 = 111 and bits 2:0 = 011, a 16-bit offset is fetched and added to the base. One word is read at that sum, and the address is the word read. `extra_cycles` is 1.
- R7: With bits 7:5 = 111 and bit 2 = 1, bits 1:0 select the offset added to the base: 00 = A, 01 = B (each zero-extended), 10 = D. `extra_cycles` is 0.
- R8: With bits 7:5 = 111 and bits 2:0 = 111, one word is read at base + D, and the address is the word read. `extra_cycles` is 1.
- R9: With `lim_mode` high, the forms of R5 and R6 are rejected. The address is 0 and `reject` is high with `done`, the cycle after `start`, with no fetch, no read and no writeback. All other forms behave as when `lim_mode` is low.
- R10: `done` is a single-cycle pulse. A `start` that arrives while a decode is in progress has no effect.
- R11: All address sums wrap modulo 2^16.
- R12: `fetch_req` stays high until `fetch_ack`. `rd_req` stays high with a stable `rd_addr` until `rd_ack`. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a decode; accepted only when idle |
| postbyte | input | 8 | Indexed-mode postbyte, sampled with start |
| lim_mode | input | 1 | Restricted mode: reject the fetched-offset forms |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| idx_sp | input | 16 | Stack pointer |
| idx_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Double accumulator D |
| fetch_req | output | 1 | Request for the next extension byte |
| fetch_ack | input | 1 | Extension byte valid |
| fetch_byte | input | 8 | Extension byte |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_ack | input | 1 | Pointer word valid |
| rd_data | input | 16 | Pointer word, high byte from the lower address |
| done | output | 1 | Result valid, one cycle |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Index writeback enable |
| wb_sel | output | 2 | Writeback register (0 X, 1 Y, 2 SP, 3 PC) |
| wb_val | output | 16 | Writeback value |
| extra_cycles | output | 2 | Extra cycles charged by the form |
| reject | output | 1 | Form refused in restricted mode |

## Verification
The hardest situation to reach from the ports is a second `start` that lands while the machine sits inside a fetch state. The result must still belong to the first postbyte. The bench's byte responder acknowledges only on every other cycle, which holds each fetch state open. The directed task then raises `start` with a different postbyte in the middle of a 16-bit offset fetch.

A second case is a restricted form that must not touch either port. The bench counts every byte and word its responders hand out, so a stray fetch or read shows up as a wrong count.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;

    typedef enum logic [2:0] {
        FORM_CONST5,
        FORM_AUTO,
        FORM_OFF9,
        FORM_OFF16,
        FORM_OFF16_IND,
        FORM_ACC,
        FORM_ACCD_IND
    } form_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_PTR_RD,
        ST_DONE
    } state_e;

    typedef struct packed {
        form_e      form;
        logic [1:0] base_sel;
        logic       post;
        logic [1:0] acc_sel;
        logic       off9_neg;
        logic       lim_form;
    } dec_t;

endpackage

// File: rtl/idx_postbyte_dec.sv
module idx_postbyte_dec
    import idx_agen_pkg::*;
(
    input  logic [7:0] pb,
    output dec_t       dec
);

    always_comb begin
        dec          = '0;
        dec.form     = FORM_CONST5;
        dec.base_sel = pb[7:6];
        if (!pb[5]) begin
            dec.form = FORM_CONST5;
        end else if (pb[7:6] != 2'b11) begin
            dec.form = FORM_AUTO;
            dec.post = pb[4];
        end else begin
            dec.base_sel = pb[4:3];
            if (pb[2:0] == 3'b011) begin
                dec.form     = FORM_OFF16_IND;
                dec.lim_form = 1'b1;
            end else if (!pb[2]) begin
                dec.form     = pb[1] ? FORM_OFF16 : FORM_OFF9;
                dec.off9_neg = pb[0];
                dec.lim_form = 1'b1;
            end else if (pb[1:0] == 2'b11) begin
                dec.form    = FORM_ACCD_IND;
                dec.acc_sel = 2'b10;
            end else begin
                dec.form    = FORM_ACC;
                dec.acc_sel = pb[1:0];
            end
        end
    end

endmodule

// File: rtl/idx_base_mux.sv
module idx_base_mux #(
    parameter int AW = 16,
    parameter int NREG = 4
) (
    input  logic [AW-1:0]           r_x,
    input  logic [AW-1:0]           r_y,
    input  logic [AW-1:0]           r_sp,
    input  logic [AW-1:0]           r_pc,
    input  logic [$clog2(NREG)-1:0] sel,
    output logic [AW-1:0]           base
);

    logic [NREG-1:0][AW-1:0] bank;

    assign bank[0] = r_x;
    assign bank[1] = r_y;
    assign bank[2] = r_sp;
    assign bank[3] = r_pc;

    assign base = bank[sel];

endmodule

// File: rtl/idx_short_off.sv
module idx_short_off
    import idx_agen_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [4:0]    pb_lo,
    input  dec_t          dec,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] off
);

    localparam int PADC = AW - 5;
    localparam int PADN = AW - 4;
    localparam int PADA = AW - DW;

    logic [AW-1:0] const5_off;
    logic [AW-1:0] auto_off;
    logic [AW-1:0] acc_off;

    assign const5_off = {{PADC{pb_lo[4]}}, pb_lo};
    assign auto_off   = pb_lo[3] ? {{PADN{1'b1}}, pb_lo[3:0]}
                                 : {{PADN{1'b0}}, pb_lo[3:0]} + AW'(1);

    always_comb begin
        unique case (dec.acc_sel)
            2'b00:   acc_off = {{PADA{1'b0}}, a};
            2'b01:   acc_off = {{PADA{1'b0}}, b};
            default: acc_off = d;
        endcase
    end

    always_comb begin
        unique case (dec.form)
            FORM_CONST5:               off = const5_off;
            FORM_AUTO:                 off = auto_off;
            FORM_ACC, FORM_ACCD_IND:   off = acc_off;
            default:                   off = '0;
        endcase
    end

endmodule

// File: rtl/idx_agen.sv
module idx_agen
    import idx_agen_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int XW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    postbyte,
    input  logic          lim_mode,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    input  logic [AW-1:0] idx_sp,
    input  logic [AW-1:0] idx_pc,
    input  logic [DW-1:0] acc_a,
    input  logic [DW-1:0] acc_b,
    input  logic [AW-1:0] acc_d,
    output logic          fetch_req,
    input  logic          fetch_ack,
    input  logic [DW-1:0] fetch_byte,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [AW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          wb_en,
    output logic [1:0]    wb_sel,
    output logic [AW-1:0] wb_val,
    output logic [XW-1:0] extra_cycles,
    output logic          reject
);

    localparam int PAD9 = AW - DW;

    state_e        state_q, state_d;
    logic [7:0]    pb_q;
    logic [7:0]    pb_cur;
    dec_t          dec;
    logic [AW-1:0] base;
    logic [AW-1:0] short_off;
    logic [AW-1:0] base_q;
    logic [DW-1:0] hi_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] ea_q;
    logic          wb_en_q;
    logic [1:0]    wb_sel_q;
    logic [AW-1:0] wb_val_q;
    logic          extra_q;
    logic          reject_q;
    logic          take;
    logic          rej_now;
    logic [AW-1:0] long_off;
    logic [AW-1:0] long_sum;
    logic [AW-1:0] mod_sum;

    assign pb_cur = (state_q == ST_IDLE) ? postbyte : pb_q;

    idx_postbyte_dec u_dec (
        .pb  (pb_cur),
        .dec (dec)
    );

    idx_base_mux #(.AW(AW), .NREG(4)) u_base (
        .r_x  (idx_x),
        .r_y  (idx_y),
        .r_sp (idx_sp),
        .r_pc (idx_pc),
        .sel  (dec.base_sel),
        .base (base)
    );

    idx_short_off #(.AW(AW), .DW(DW)) u_off (
        .pb_lo (pb_cur[4:0]),
        .dec   (dec),
        .a     (acc_a),
        .b     (acc_b),
        .d     (acc_d),
        .off   (short_off)
    );

    assign take     = (state_q == ST_IDLE) && start;
    assign rej_now  = lim_mode && dec.lim_form;
    assign mod_sum  = base + short_off;
    assign long_off = (dec.form == FORM_OFF9) ? {{PAD9{dec.off9_neg}}, fetch_byte}
                                              : AW'({hi_q, fetch_byte});
    assign long_sum = base_q + long_off;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (rej_now) begin
                        state_d = ST_DONE;
                    end else begin
                        unique case (dec.form)
                            FORM_OFF9:                  state_d = ST_FETCH_LO;
                            FORM_OFF16, FORM_OFF16_IND: state_d = ST_FETCH_HI;
                            FORM_ACCD_IND:              state_d = ST_PTR_RD;
                            default:                    state_d = ST_DONE;
                        endcase
                    end
                end
            end
            ST_FETCH_HI: if (fetch_ack) state_d = ST_FETCH_LO;
            ST_FETCH_LO: if (fetch_ack) state_d = (dec.form == FORM_OFF16_IND) ? ST_PTR_RD : ST_DONE;
            ST_PTR_RD:   if (rd_ack) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q     <= '0;
            base_q   <= '0;
            hi_q     <= '0;
            addr_q   <= '0;
            ea_q     <= '0;
            wb_en_q  <= 1'b0;
            wb_sel_q <= '0;
            wb_val_q <= '0;
            extra_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            if (take) begin
                pb_q     <= postbyte;
                base_q   <= base;
                addr_q   <= mod_sum;
                reject_q <= rej_now;
                wb_en_q  <= (dec.form == FORM_AUTO);
                wb_sel_q <= dec.base_sel;
                wb_val_q <= mod_sum;
                extra_q  <= !rej_now && (dec.form == FORM_OFF9 || dec.form == FORM_OFF16 ||
                                         dec.form == FORM_OFF16_IND || dec.form == FORM_ACCD_IND);
                if (rej_now)
                    ea_q <= '0;
                else if (dec.form == FORM_AUTO && dec.post)
                    ea_q <= base;
                else
                    ea_q <= mod_sum;
            end
            if (state_q == ST_FETCH_HI && fetch_ack)
                hi_q <= fetch_byte;
            if (state_q == ST_FETCH_LO && fetch_ack) begin
                ea_q   <= long_sum;
                addr_q <= long_sum;
            end
            if (state_q == ST_PTR_RD && rd_ack)
                ea_q <= rd_data;
        end
    end

    // outputs
    always_comb begin
        done         = (state_q == ST_DONE);
        fetch_req    = (state_q == ST_FETCH_HI) || (state_q == ST_FETCH_LO);
        rd_req       = (state_q == ST_PTR_RD);
        rd_addr      = addr_q;
        ea           = ea_q;
        wb_en        = done && wb_en_q;
        wb_sel       = wb_sel_q;
        wb_val       = wb_val_q;
        extra_cycles = XW'(extra_q);
        reject       = done && reject_q;
    end

endmodule

// File: rtl/idx_agen_chk.sv
module idx_agen_chk #(
    parameter int AW = 16,
    parameter int XW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic          fetch_ack,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          done,
    input logic [AW-1:0] ea,
    input logic          wb_en,
    input logic [XW-1:0] extra_cycles,
    input logic          reject
);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_wb_auto_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !reject));

    p_reject_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (done && ea == '0 && extra_cycles == '0));

    p_fetch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> fetch_req);

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    p_one_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && rd_req));

    p_idle_when_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!fetch_req && !rd_req));

endmodule

bind idx_agen idx_agen_chk #(.AW(AW), .XW(XW)) u_chk (.*);

// File: tb/idx_agen_bench.sv
module idx_agen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic        lim_mode = 1'b0;
    logic [15:0] idx_x = 16'h1000, idx_y = 16'h2000, idx_sp = 16'h3FF0, idx_pc = 16'h8000;
    logic [7:0]  acc_a = 8'h80, acc_b = 8'hFF;
    logic [15:0] acc_d = 16'h1234;
    logic        fetch_req, fetch_ack = 1'b0;
    logic [7:0]  fetch_byte = '0;
    logic        rd_req, rd_ack = 1'b0;
    logic [15:0] rd_addr, rd_data = '0;
    logic        done, wb_en, reject;
    logic [15:0] ea, wb_val;
    logic [1:0]  wb_sel, extra_cycles;

    int n_tests = 0, n_fail = 0;
    int f_cnt = 0, r_cnt = 0;
    logic [7:0]  fb [2];
    logic [15:0] last_rd = '0;

    always #4 clk = ~clk;

    idx_agen u_idx_agen (.*);

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A5A;
    endfunction

    always @(negedge clk) begin
        if (fetch_ack) begin
            fetch_ack <= 1'b0;
            f_cnt     <= f_cnt + 1;
        end else if (fetch_req) begin
            fetch_ack  <= 1'b1;
            fetch_byte <= fb[f_cnt % 2];
        end
        if (rd_ack) begin
            rd_ack <= 1'b0;
            r_cnt  <= r_cnt + 1;
        end else if (rd_req) begin
            rd_ack  <= 1'b1;
            rd_data <= mem_word(rd_addr);
            last_rd <= rd_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [7:0] pb, input logic rs, input logic [15:0] e_ea,
                            input logic e_wb, input logic [1:0] e_sel, input logic [15:0] e_val,
                            input logic [1:0] e_ex, input logic e_rej, input int e_f, input int e_r,
                            input logic [7:0] b0, input logic [7:0] b1, input bit poke,
                            input string tag);
        int cyc;
        @(negedge clk);
        f_cnt = 0; r_cnt = 0;
        fb[0] = b0; fb[1] = b1;
        postbyte = pb; lim_mode = rs; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cyc = 1;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin start = 1'b1; postbyte = 8'h00; end
            else start = 1'b0;
        end
        chk(done, tag, "done", 32'(done), 32'd1);
        chk(ea == e_ea, tag, "ea", 32'(ea), 32'(e_ea));
        chk(wb_en == e_wb, tag, "wb_en", 32'(wb_en), 32'(e_wb));
        if (e_wb) begin
            chk(wb_sel == e_sel, tag, "wb_sel", 32'(wb_sel), 32'(e_sel));
            chk(wb_val == e_val, tag, "wb_val", 32'(wb_val), 32'(e_val));
        end
        chk(extra_cycles == e_ex, tag, "extra", 32'(extra_cycles), 32'(e_ex));
        chk(reject == e_rej, tag, "reject", 32'(reject), 32'(e_rej));
        if (e_f == 0 && e_r == 0)
            chk(cyc == 1, tag, "latency", 32'(cyc), 32'd1);
        @(negedge clk);
        chk(!done, "R10", "done pulse", 32'(done), 32'd0);
        chk(f_cnt == e_f, tag, "fetch count", 32'(f_cnt), 32'(e_f));
        chk(r_cnt == e_r, tag, "read count", 32'(r_cnt), 32'(e_r));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !fetch_req && !rd_req && !wb_en, "R12", "reset idle",
            {28'd0, done, fetch_req, rd_req, wb_en}, 32'd0);

        // R1 short constant offsets, every base register
        run_case(8'h05, 0, 16'h1005, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        run_case(8'h5F, 0, 16'h1FFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        run_case(8'h90, 0, 16'h3FE0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        run_case(8'hC7, 0, 16'h8007, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R2 R3 R4 auto modify
        run_case(8'h22, 0, 16'h1003, 1, 2'd0, 16'h1003, 0, 0, 0, 0, 0, 0, 0, "R4");
        run_case(8'h7F, 0, 16'h2000, 1, 2'd1, 16'h1FFF, 0, 0, 0, 0, 0, 0, 0, "R2");
        run_case(8'hA8, 0, 16'h3FE8, 1, 2'd2, 16'h3FE8, 0, 0, 0, 0, 0, 0, 0, "R3");
        run_case(8'h37, 0, 16'h1000, 1, 2'd0, 16'h1008, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R5 fetched offsets
        run_case(8'hE0, 0, 16'h1040, 0, 0, 0, 1, 0, 1, 0, 8'h40, 8'h00, 0, "R5");
        run_case(8'hE9, 0, 16'h1F10, 0, 0, 0, 1, 0, 1, 0, 8'h10, 8'h00, 0, "R5");
        run_case(8'hF2, 0, 16'h5224, 0, 0, 0, 1, 0, 2, 0, 8'h12, 8'h34, 0, "R5");
        // R10 start during a fetch is ignored
        run_case(8'hF2, 0, 16'h5224, 0, 0, 0, 1, 0, 2, 0, 8'h12, 8'h34, 1, "R10");
        // R11 wrap
        run_case(8'hFA, 0, 16'h1000, 0, 0, 0, 1, 0, 2, 0, 8'h90, 8'h00, 0, "R11");
        // R6 indirect through fetched offset
        run_case(8'hE3, 0, mem_word(16'h1020), 0, 0, 0, 1, 0, 2, 1, 8'h00, 8'h20, 0, "R6");
        chk(last_rd == 16'h1020, "R6", "pointer addr", 32'(last_rd), 32'h1020);
        // R7 accumulators
        run_case(8'hE4, 0, 16'h1080, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        run_case(8'hED, 0, 16'h20FF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        run_case(8'hF6, 0, 16'h5224, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R8 D indirect
        run_case(8'hFF, 0, mem_word(16'h9234), 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, "R8");
        chk(last_rd == 16'h9234, "R8", "pointer addr", 32'(last_rd), 32'h9234);
        // R9 restricted mode
        run_case(8'hE0, 1, 16'h0000, 0, 0, 0, 0, 1, 0, 0, 8'h40, 8'h00, 0, "R9");
        run_case(8'hF2, 1, 16'h0000, 0, 0, 0, 0, 1, 0, 0, 8'h12, 8'h34, 0, "R9");
        run_case(8'hE3, 1, 16'h0000, 0, 0, 0, 0, 1, 0, 0, 8'h00, 8'h20, 0, "R9");
        run_case(8'hE4, 1, 16'h1080, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        run_case(8'hFF, 1, mem_word(16'h9234), 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, "R9");
        run_case(8'h22, 1, 16'h1003, 1, 2'd0, 16'h1003, 0, 0, 0, 0, 0, 0, 0, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule